// File: doc/BRIEF.md
# Multidrop Serial Receiver with Ninth-Bit Address Filter

This block receives asynchronous serial frames on a single line and stores them in a small receive queue. It is meant for multidrop buses where many nodes share one line. A ninth data bit marks a frame as an address (1) or as data (0). While the address filter is on, frames carrying a ninth bit of 0 are dropped in hardware. As a result, the processor is interrupted only for address frames. When software sees its own address, it turns the filter off, and all following frames, both data and address, reach the queue.

The bit rate comes from the block clock. A programmable divisor produces a sampling tick, and each bit lasts 16 ticks in fast mode or 64 ticks in slow mode. Each bit is decided by a vote among three samples taken around the centre of the bit. Outputs are the oldest queued byte, its ninth bit, its framing-error flag, a sticky overrun flag, a ready flag and an interrupt.

Top module: `uart9_addr_rx`

## Requirements
- R1: One bit lasts (divisor+1)*16 clock cycles when `fast_sel`=1, and (divisor+1)*64 clock cycles when `fast_sel`=0. Frames sent at that rate are received correctly for every divisor.
- R2: Reception happens only while `port_en`=1, `sync_mode`=0 and `rx_enable`=1. A frame sent at any other time leaves the queue and flags unchanged.
- R3: When `nine_bit_en`=1, a frame is: start (0), 9 data bits LSB first, stop (1). Data bit 8 appears on `rx_bit8`. When `nine_bit_en`=0, the frame has 8 data bits and `rx_bit8` reads 0.
- R4: When `addr_filter_en`=1 and `nine_bit_en`=1, a completed frame whose ninth bit is 0 is discarded. It does not enter the queue and changes no flag.
- R5: When `addr_filter_en`=0, or when `nine_bit_en`=0, every completed frame enters the queue.
- R6: `rx_ready` is 1 while the queue holds at least one entry. `irq` equals `rx_ready` AND `irq_en`.
- R7: The queued framing-error bit `rx_ferr` is 1 when the stop bit was sampled as 0, and 0 otherwise.
- R8: If a frame that would be kept completes while the 2-entry queue is full, `ovr_err` is set and the frame is lost. While `ovr_err` is 1, no frame is loaded, even after the queue has been popped.
- R9: Driving `rx_enable` to 0 clears `ovr_err` and resets the frame receiver. Entries already in the queue are kept.
- R10: The queue is first-in first-out and holds 2 entries. A one-cycle `rd_pop` while `rx_ready`=1 removes the head entry. `rd_pop` has no effect while the queue is empty.
- R11: A falling edge that returns high before the bit centre is rejected as a false start and produces no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select; receiver is idle while 1 |
| rx_enable | input | 1 | Continuous-receive enable; 0 clears overrun and resets the receiver |
| nine_bit_en | input | 1 | 1 = 9 data bits per frame, 0 = 8 data bits |
| addr_filter_en | input | 1 | Drop frames whose ninth bit is 0 (only when nine_bit_en=1) |
| fast_sel | input | 1 | 1 = 16 ticks per bit, 0 = 64 ticks per bit |
| divisor | input | 8 | Tick period minus one, in clock cycles |
| irq_en | input | 1 | Interrupt enable |
| rxd | input | 1 | Serial input line, idle high |
| rd_pop | input | 1 | Removes the head queue entry |
| rx_byte | output | 8 | Head entry data byte |
| rx_bit8 | output | 1 | Head entry ninth bit |
| rx_ferr | output | 1 | Head entry framing-error bit |
| ovr_err | output | 1 | Sticky overrun flag |
| rx_ready | output | 1 | Queue not empty |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest state to reach is overrun with the filter active. To get there, the queue must be filled by two kept frames. A third kept frame must then arrive. Discarded data frames sent in between must not count toward filling the queue. After that, a pop must still not let a new frame in until `rx_enable` is pulsed low. The bench reaches this with a directed sequence: two address frames, one data frame, one more address frame, a pop, and then one more frame. Randomised frames then mix the filter, the frame width, stop-bit errors and pops, against a queue model kept in the bench.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
    localparam int OSR_FAST = 16;
    localparam int OSR_SLOW = 64;
    localparam int PH_W     = $clog2(OSR_SLOW);

    typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;

    typedef struct packed {
        logic       ferr;
        logic       bit8;
        logic [7:0] data;
    } rx_word_t;

    localparam int WORD_W = $bits(rx_word_t);
endpackage

// File: rtl/uart9_baud_gen.sv
module uart9_baud_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } bg_t;

    bg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        tick = 1'b0;
        if (!en) begin
            s_d.cnt = '0;
        end else if (s_q.cnt >= divisor) begin
            s_d.cnt = '0;
            tick = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1: the counter restarts from zero whenever the receiver is off
    a_r1_cnt_cleared_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (s_q.cnt == '0));
endmodule

// File: rtl/uart9_rx_shift.sv
module uart9_rx_shift
    import uart9_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     tick,
    input  logic     fast,
    input  logic     nine,
    input  logic     rxd,
    output logic     done,
    output rx_word_t word
);
    typedef struct packed {
        rx_state_e        st;
        logic [1:0]       sync;
        logic             prev;
        logic [PH_W-1:0]  phase;
        logic [1:0]       votes;
        logic [3:0]       bitcnt;
        logic [8:0]       sr;
        logic             done;
        rx_word_t         word;
    } sh_t;

    sh_t s_d, s_q;

    logic            line;
    logic [PH_W-1:0] ph_last, ph_mid;
    logic [1:0]      vote_sum;
    logic            bitval;
    logic            sampling;

    assign line     = s_q.sync[1];
    assign ph_last  = fast ? PH_W'(OSR_FAST - 1) : PH_W'(OSR_SLOW - 1);
    assign ph_mid   = fast ? PH_W'(OSR_FAST / 2) : PH_W'(OSR_SLOW / 2);
    assign sampling = (s_q.phase == ph_mid - 1'b1) || (s_q.phase == ph_mid) ||
                      (s_q.phase == ph_mid + 1'b1);
    assign vote_sum = s_q.votes + {1'b0, line};
    assign bitval   = vote_sum >= 2'd2;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.sync = {s_q.sync[0], rxd};
        s_d.prev = line;
        if (!en) begin
            s_d.st     = ST_IDLE;
            s_d.phase  = '0;
            s_d.votes  = '0;
            s_d.bitcnt = '0;
        end else if (s_q.st == ST_IDLE) begin
            if (s_q.prev && !line) begin
                s_d.st    = ST_START;
                s_d.phase = '0;
                s_d.votes = '0;
            end
        end else if (tick) begin
            s_d.phase = s_q.phase + 1'b1;
            if (sampling) s_d.votes = vote_sum;
            if (s_q.phase == ph_mid + 1'b1) begin
                case (s_q.st)
                    ST_START: if (bitval) s_d.st = ST_IDLE;
                    ST_DATA: begin
                        s_d.sr     = {bitval, s_q.sr[8:1]};
                        s_d.bitcnt = s_q.bitcnt + 1'b1;
                    end
                    ST_STOP: begin
                        s_d.done      = 1'b1;
                        s_d.word.ferr = !bitval;
                        s_d.word.bit8 = nine ? s_q.sr[8] : 1'b0;
                        s_d.word.data = nine ? s_q.sr[7:0] : s_q.sr[8:1];
                        s_d.st        = ST_IDLE;
                    end
                    default: ;
                endcase
            end
            if (s_q.phase == ph_last) begin
                s_d.phase = '0;
                s_d.votes = '0;
                if (s_q.st == ST_START) begin
                    s_d.st     = ST_DATA;
                    s_d.bitcnt = '0;
                end else if (s_q.st == ST_DATA &&
                             s_q.bitcnt == (nine ? 4'd9 : 4'd8)) begin
                    s_d.st = ST_STOP;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.sync <= 2'b11;
            s_q.prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign done = s_q.done;
    assign word = s_q.word;

    // R2: a disabled receiver is back in idle on the next cycle
    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (s_q.st == ST_IDLE));
    // R7: a frame completion is a single-cycle event
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11: a frame only completes from the stop state
    a_r11_done_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        s_d.done |-> (s_q.st == ST_STOP));
endmodule

// File: rtl/uart9_rx_fifo.sv
module uart9_rx_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [LW-1:0]           cnt;
    } ff_t;

    ff_t s_d, s_q;
    logic do_push, do_pop;

    assign empty   = (s_q.cnt == '0);
    assign full    = (s_q.cnt == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (do_push) begin
            s_d.mem[s_q.wp] = wdata;
            s_d.wp          = inc_ptr(s_q.wp);
        end
        if (do_pop) s_d.rp = inc_ptr(s_q.rp);
        s_d.cnt = s_q.cnt + LW'(do_push) - LW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.mem[s_q.rp];
    assign level = s_q.cnt;

    // R10: never written beyond capacity
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R10: occupancy stays within the depth
    a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LW'(DEPTH));
endmodule

// File: rtl/uart9_addr_rx.sv
module uart9_addr_rx
    import uart9_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int QDEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic             sync_mode,
    input  logic             rx_enable,
    input  logic             nine_bit_en,
    input  logic             addr_filter_en,
    input  logic             fast_sel,
    input  logic [DIV_W-1:0] divisor,
    input  logic             irq_en,
    input  logic             rxd,
    input  logic             rd_pop,
    output logic [7:0]       rx_byte,
    output logic             rx_bit8,
    output logic             rx_ferr,
    output logic             ovr_err,
    output logic             rx_ready,
    output logic             irq
);
    localparam int LW = $clog2(QDEPTH + 1);

    typedef struct packed {
        logic ovr;
    } top_t;

    top_t s_d, s_q;

    logic          rx_on, tick, frame_done, keep, push, q_empty, q_full;
    rx_word_t      frame, head;
    logic [LW-1:0] q_level;

    assign rx_on = port_en && !sync_mode && rx_enable;

    uart9_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .en(rx_on), .divisor(divisor), .tick(tick)
    );

    uart9_rx_shift u_shift (
        .clk(clk), .rst_n(rst_n), .en(rx_on), .tick(tick), .fast(fast_sel),
        .nine(nine_bit_en), .rxd(rxd), .done(frame_done), .word(frame)
    );

    always_comb begin
        s_d  = s_q;
        keep = frame_done && !(addr_filter_en && nine_bit_en && !frame.bit8);
        push = keep && !s_q.ovr && !q_full;
        if (!rx_enable)                  s_d.ovr = 1'b0;
        else if (keep && q_full)         s_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    uart9_rx_fifo #(.DEPTH(QDEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(frame), .pop(rd_pop),
        .rdata(head), .empty(q_empty), .full(q_full), .level(q_level)
    );

    assign rx_byte  = head.data;
    assign rx_bit8  = head.bit8;
    assign rx_ferr  = head.ferr;
    assign ovr_err  = s_q.ovr;
    assign rx_ready = !q_empty;
    assign irq      = rx_ready && irq_en;

    // R8: overrun is sticky while reception stays enabled
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && rx_enable) |=> ovr_err);
    // R9: dropping the receive enable clears overrun
    a_r9_ovr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !ovr_err);
    // R4: a filtered data frame leaves the queue level unchanged
    a_r4_filtered_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && addr_filter_en && nine_bit_en && !frame.bit8 && !rd_pop)
        |=> $stable(q_level));
    // R8: no load while overrun is pending
    a_r8_no_load_in_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && !rd_pop) |=> (q_level <= $past(q_level)));
endmodule

// File: tb/uart9_addr_rx_tb.sv
module uart9_addr_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b1, sync_mode = 1'b0, rx_enable = 1'b1;
    logic       nine_bit_en = 1'b1, addr_filter_en = 1'b0, fast_sel = 1'b1;
    logic [7:0] divisor = 8'd0;
    logic       irq_en = 1'b1, rxd = 1'b1, rd_pop = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_bit8, rx_ferr, ovr_err, rx_ready, irq;

    int n_chk = 0, n_bad = 0;
    logic [9:0] expq[$];
    logic       exp_ovr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart9_addr_rx u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
        .rx_enable(rx_enable), .nine_bit_en(nine_bit_en),
        .addr_filter_en(addr_filter_en), .fast_sel(fast_sel), .divisor(divisor),
        .irq_en(irq_en), .rxd(rxd), .rd_pop(rd_pop), .rx_byte(rx_byte),
        .rx_bit8(rx_bit8), .rx_ferr(rx_ferr), .ovr_err(ovr_err),
        .rx_ready(rx_ready), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int bit_cycles();
        return (int'(divisor) + 1) * (fast_sel ? 16 : 64);
    endfunction

    function automatic logic frame_kept(input logic b8);
        return !(addr_filter_en && nine_bit_en && !b8);
    endfunction

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic b8, input logic stopb);
        int bp = bit_cycles();
        logic active = port_en && !sync_mode && rx_enable;
        hold(1'b0, bp);
        for (int i = 0; i < 8; i++) hold(b[i], bp);
        if (nine_bit_en) hold(b8, bp);
        hold(stopb, bp);
        hold(1'b1, bp);
        if (active && frame_kept(nine_bit_en ? b8 : 1'b0)) begin
            if (exp_ovr) ;
            else if (expq.size() == DEPTH) exp_ovr = 1'b1;
            else expq.push_back({!stopb, nine_bit_en ? b8 : 1'b0, b});
        end
    endtask

    task automatic check_all(input string tag);
        check(rx_ready, expq.size() > 0, {tag, " R6 ready"});
        check(irq, (expq.size() > 0) && irq_en, {tag, " R6 irq"});
        check(ovr_err, exp_ovr, {tag, " R8 ovr"});
        if (expq.size() > 0) begin
            check(rx_byte, expq[0][7:0], {tag, " R3 byte"});
            check(rx_bit8, expq[0][8], {tag, " R3 bit8"});
            check(rx_ferr, expq[0][9], {tag, " R7 ferr"});
        end
    endtask

    task automatic pop_one();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        if (expq.size() > 0) void'(expq.pop_front());
        @(negedge clk);
        check_all("R10 pop");
    endtask

    task automatic drain();
        while (expq.size() > 0) pop_one();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_all("R6 reset");

        // R3/R1: 9-bit frames at two divisors, fast speed
        send(8'hA5, 1'b1, 1'b1); check_all("R3 nine d0");
        pop_one();
        divisor = 8'd2;
        send(8'h3C, 1'b0, 1'b1); check_all("R1 div2");
        pop_one();
        // R1: slow path
        fast_sel = 1'b0; divisor = 8'd0;
        send(8'h81, 1'b1, 1'b1); check_all("R1 slow");
        pop_one();
        fast_sel = 1'b1;
        // R3: 8-bit mode, bit8 reads 0
        nine_bit_en = 1'b0;
        send(8'h7E, 1'b1, 1'b1); check_all("R3 eight");
        // R5: filter ignored when 8-bit mode
        addr_filter_en = 1'b1;
        send(8'h12, 1'b0, 1'b1); check_all("R5 filter 8bit");
        drain();
        // R4: filtered data frame discarded, address frame kept
        nine_bit_en = 1'b1;
        send(8'h44, 1'b0, 1'b1); check_all("R4 drop data");
        send(8'h05, 1'b1, 1'b1); check_all("R4 addr kept");
        // R4/R8: fill, drop data, then overrun on address frame
        send(8'h06, 1'b1, 1'b1); check_all("R8 full");
        send(8'h77, 1'b0, 1'b1); check_all("R4 full drop");
        send(8'h07, 1'b1, 1'b1); check_all("R8 overrun");
        pop_one();
        send(8'h08, 1'b1, 1'b1); check_all("R8 blocked");
        // R9: dropping rx_enable clears overrun, keeps queue
        rx_enable = 1'b0; repeat (3) @(negedge clk); exp_ovr = 1'b0;
        check_all("R9 clear");
        send(8'h09, 1'b1, 1'b1); check_all("R2 rx off");
        rx_enable = 1'b1; repeat (2) @(negedge clk);
        drain();
        // R5: filter off passes data frames
        addr_filter_en = 1'b0;
        send(8'hC3, 1'b0, 1'b1); check_all("R5 data pass");
        // R7: framing error
        send(8'h5A, 1'b1, 1'b0); check_all("R7 ferr");
        drain();
        // R2: disabled by port_en and sync_mode
        port_en = 1'b0; send(8'h11, 1'b1, 1'b1); check_all("R2 port off");
        port_en = 1'b1; sync_mode = 1'b1; send(8'h22, 1'b1, 1'b1); check_all("R2 sync");
        sync_mode = 1'b0; repeat (2) @(negedge clk);
        // R10: pop on empty queue has no effect
        pop_one();
        // R11: short glitch is rejected
        hold(1'b0, bit_cycles() / 4); hold(1'b1, 3 * bit_cycles());
        check_all("R11 glitch");
        // R6: irq gated by irq_en
        irq_en = 1'b0; send(8'h99, 1'b1, 1'b1); check_all("R6 irq off");
        irq_en = 1'b1; drain();

        // random section
        for (int k = 0; k < 30; k++) begin
            logic [7:0] b = 8'($urandom);
            logic b8 = 1'($urandom);
            logic sb = ($urandom % 8) != 0;
            divisor = 8'($urandom % 3);
            nine_bit_en = ($urandom % 4) != 0;
            addr_filter_en = 1'($urandom);
            send(b, b8, sb);
            check_all("R4 R5 random");
            if (($urandom % 3) != 0) pop_one();
            if (exp_ovr && ($urandom % 2)) begin
                rx_enable = 1'b0; repeat (2) @(negedge clk);
                exp_ovr = 1'b0; rx_enable = 1'b1; repeat (2) @(negedge clk);
                check_all("R9 random");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule